// File: doc/BRIEF.md
# Delayed Conditional Branch Sequencer

This block owns the program counter of a 32-bit fetch front end and carries out a conditional branch whose redirect is deferred by three delay slots. Whenever the fetch-advance strobe is high, the instruction word on `instr` is the one fetched from the current `pc`. If `br_valid` marks that word as a branch, the block works out three things in the same cycle. It evaluates the branch condition against the flags present at that moment. It reads the register file through `rf_idx`/`rf_data`, or it adds the signed displacement to the branch address plus three. It then records the decision and the target.

After a taken branch, the PC keeps stepping by one for exactly three more fetch strobes, which fetch the three delay-slot instructions. The fourth strobe loads the captured target. Nothing that happens during the slots can change the decision. This includes new flag values and further branches. A further branch is ignored and sets a sticky error. A register index outside the file also sets a sticky error, and no branch is taken.

The control is a four-state machine. `ST_IDLE` handles sequential fetch and branch decode. `ST_SLOT1`, `ST_SLOT2` and `ST_SLOT3` count the delay-slot fetches. The transitions are:

- `ST_IDLE` to `ST_SLOT1`, on a strobe carrying a taken branch.
- `ST_SLOT1` to `ST_SLOT2`, and `ST_SLOT2` to `ST_SLOT3`, on each strobe.
- `ST_SLOT3` to `ST_IDLE`, on the strobe that performs the redirect.
- Any state to `ST_IDLE`, on the synchronous reset.

Without a strobe, every state holds.

Top module: `dcb_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) loads `pc` with `rst_vec`, returns to `ST_IDLE` and clears `idx_err` and `nest_err`.
- R2: A fetch strobe with no branch while idle advances `pc` by one, modulo 2^32 (0xFFFFFFFF is followed by 0).
- R3: Without `fetch_adv`, `pc` keeps its value.
- R4: After the strobe of a taken branch at address A, `pc` reads A+1, A+2 and A+3 after that strobe and the next two strobes, and it reads the target after the third strobe that follows the branch.
- R5: A branch whose condition is false leaves `pc` sequential: A+1, A+2, A+3, A+4.
- R6: The condition uses `flags` as sampled on the branch strobe; flag changes during the delay slots do not alter the outcome. Flag bits: 0 C, 1 V, 2 Z, 3 N, 4 UF, 5 LV, 6 LUF.
- R7: Bit 25 of `instr` set to 0 selects register mode. `rf_idx` carries `instr[4:0]`, and the target is `rf_data` as sampled on the branch strobe.
- R8: Bit 25 set to 1 selects PC-relative mode. The target is A + 3 + sign-extended `instr[15:0]`, modulo 2^32.
- R9: The condition code `instr[20:16]` decides whether the branch is taken. The codes are: 0 always; 1 C; 2 C|Z; 3 ~C&~Z; 4 ~C; 5 Z; 6 ~Z; 7 N; 8 N|Z; 9 ~N&~Z; 10 ~N; 12 ~V; 13 V; 14 ~UF; 15 UF; 16 ~LV; 17 LV; 18 ~LUF; 19 LUF; 20 Z|UF.
- R10: Codes 11 and 21 to 31 are never taken.
- R11: In register mode, a value of `instr[15:0]` above 27 sets sticky `idx_err` and no branch is taken.
- R12: A branch arriving in any slot state is ignored (the original redirect still happens once) and sets sticky `nest_err`.
- R13: A reset while a redirect is pending cancels it; the following strobes are sequential from `rst_vec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rst_vec | input | 32 | PC value loaded on reset |
| fetch_adv | input | 1 | Fetch-advance strobe |
| br_valid | input | 1 | Current instruction word is a conditional branch |
| instr | input | 32 | Instruction word fetched from `pc` |
| flags | input | 7 | Status flags {LUF, LV, UF, N, Z, V, C} |
| rf_idx | output | 5 | Register-file read index |
| rf_data | input | 32 | Register-file read data |
| pc | output | 32 | Current fetch address |
| idx_err | output | 1 | Sticky: illegal register index seen |
| nest_err | output | 1 | Sticky: branch seen while a redirect was pending |

## Verification
Every internal fault in this block shows up on `pc` within at most four fetch strobes of a branch. A slot counter that is wrong moves the redirect one strobe early or late. A condition decoded wrongly, or flags sampled in the wrong cycle, gives a target where A+4 was due, or the reverse. A wrong target computation leaves a wrong address in the first cycle after the redirect. The sticky error outputs expose an incorrect decision between ignoring a branch and accepting it in the cycle after the offending strobe. A missed reset appears on `pc` in the first cycle after reset.

// File: rtl/dcb_pkg.sv
`timescale 1ns/1ps
package dcb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SLOT1 = 2'd1,
        ST_SLOT2 = 2'd2,
        ST_SLOT3 = 2'd3
    } seq_st_e;

    localparam int FLG_W  = 7;
    localparam int COND_W = 5;
    localparam int FB_C   = 0;
    localparam int FB_V   = 1;
    localparam int FB_Z   = 2;
    localparam int FB_N   = 3;
    localparam int FB_UF  = 4;
    localparam int FB_LV  = 5;
    localparam int FB_LUF = 6;
endpackage

// File: rtl/dcb_cond_eval.sv
`timescale 1ns/1ps
module dcb_cond_eval
    import dcb_pkg::*;
(
    input  logic [COND_W-1:0] code,
    input  logic [FLG_W-1:0]  flg,
    output logic              take
);
    logic c, v, z, n, uf, lv, luf;
    assign c   = flg[FB_C];
    assign v   = flg[FB_V];
    assign z   = flg[FB_Z];
    assign n   = flg[FB_N];
    assign uf  = flg[FB_UF];
    assign lv  = flg[FB_LV];
    assign luf = flg[FB_LUF];

    // R9 condition table, R10 reserved codes fall to default
    always_comb begin
        case (code)
            5'd0:    take = 1'b1;
            5'd1:    take = c;
            5'd2:    take = c | z;
            5'd3:    take = ~c & ~z;
            5'd4:    take = ~c;
            5'd5:    take = z;
            5'd6:    take = ~z;
            5'd7:    take = n;
            5'd8:    take = n | z;
            5'd9:    take = ~n & ~z;
            5'd10:   take = ~n;
            5'd12:   take = ~v;
            5'd13:   take = v;
            5'd14:   take = ~uf;
            5'd15:   take = uf;
            5'd16:   take = ~lv;
            5'd17:   take = lv;
            5'd18:   take = ~luf;
            5'd19:   take = luf;
            5'd20:   take = z | uf;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/dcb_target_calc.sv
`timescale 1ns/1ps
module dcb_target_calc #(
    parameter int PC_W   = 32,
    parameter int DISP_W = 16,
    parameter int SLOTS  = 3
) (
    input  logic              rel,
    input  logic [PC_W-1:0]   br_pc,
    input  logic [DISP_W-1:0] disp,
    input  logic [PC_W-1:0]   reg_val,
    output logic [PC_W-1:0]   target
);
    localparam int EXT_W = PC_W - DISP_W;
    logic [PC_W-1:0] disp_ext;

    assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    // R8 relative target wraps modulo 2^PC_W; R7 register target
    assign target = rel ? (br_pc + PC_W'(SLOTS) + disp_ext) : reg_val;
endmodule

// File: rtl/dcb_seq.sv
`timescale 1ns/1ps
module dcb_seq
    import dcb_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int DISP_W   = 16,
    parameter int REG_CNT  = 28,
    parameter int IDX_W    = $clog2(REG_CNT),
    parameter int MODE_BIT = 25,
    parameter int COND_LSB = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PC_W-1:0]   rst_vec,
    input  logic              fetch_adv,
    input  logic              br_valid,
    input  logic [31:0]       instr,
    input  logic [FLG_W-1:0]  flags,
    output logic [IDX_W-1:0]  rf_idx,
    input  logic [PC_W-1:0]   rf_data,
    output logic [PC_W-1:0]   pc,
    output logic              idx_err,
    output logic              nest_err
);
    localparam logic [PC_W-1:0] ONE = PC_W'(1);

    seq_st_e           st_q, st_d;
    logic [PC_W-1:0]   pc_q, pc_d;
    logic [PC_W-1:0]   tgt_q, tgt_d;
    logic              ierr_q, ierr_d;
    logic              nerr_q, nerr_d;

    logic              mode_rel;
    logic [COND_W-1:0] code;
    logic [DISP_W-1:0] fld;
    logic              idx_bad;
    logic              cond_true;
    logic              take_now;
    logic [PC_W-1:0]   tgt_calc;
    logic              unused_bits;

    assign mode_rel    = instr[MODE_BIT];
    assign code        = instr[COND_LSB +: COND_W];
    assign fld         = instr[DISP_W-1:0];
    assign unused_bits = ^{instr[31:MODE_BIT+1], instr[MODE_BIT-1:COND_LSB+COND_W]};
    assign idx_bad     = !mode_rel && (fld > DISP_W'(REG_CNT - 1));
    assign rf_idx      = fld[IDX_W-1:0];

    dcb_cond_eval u_cond (
        .code (code),
        .flg  (flags),
        .take (cond_true)
    );

    dcb_target_calc #(
        .PC_W   (PC_W),
        .DISP_W (DISP_W),
        .SLOTS  (3)
    ) u_tgt (
        .rel     (mode_rel),
        .br_pc   (pc_q),
        .disp    (fld),
        .reg_val (rf_data),
        .target  (tgt_calc)
    );

    assign take_now = cond_true && !idx_bad;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            pc_q   <= rst_vec;
            tgt_q  <= '0;
            ierr_q <= 1'b0;
            nerr_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            pc_q   <= pc_d;
            tgt_q  <= tgt_d;
            ierr_q <= ierr_d;
            nerr_q <= nerr_d;
        end
    end

    // next state and outputs
    always_comb begin
        st_d   = st_q;
        pc_d   = pc_q;
        tgt_d  = tgt_q;
        ierr_d = ierr_q;
        nerr_d = nerr_q;
        if (fetch_adv) begin
            unique case (st_q)
                ST_IDLE: begin
                    pc_d = pc_q + ONE;
                    if (br_valid) begin
                        if (idx_bad) ierr_d = 1'b1;
                        if (take_now) begin
                            tgt_d = tgt_calc;
                            st_d  = ST_SLOT1;
                        end
                    end
                end
                ST_SLOT1: begin
                    pc_d = pc_q + ONE;
                    st_d = ST_SLOT2;
                    if (br_valid) nerr_d = 1'b1;
                end
                ST_SLOT2: begin
                    pc_d = pc_q + ONE;
                    st_d = ST_SLOT3;
                    if (br_valid) nerr_d = 1'b1;
                end
                ST_SLOT3: begin
                    pc_d = tgt_q;
                    st_d = ST_IDLE;
                    if (br_valid) nerr_d = 1'b1;
                end
            endcase
        end
    end

    assign pc       = pc_q;
    assign idx_err  = ierr_q;
    assign nest_err = nerr_q;
endmodule

// File: rtl/dcb_seq_chk.sv
`timescale 1ns/1ps
module dcb_seq_chk
    import dcb_pkg::*;
#(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] rst_vec,
    input logic            fetch_adv,
    input logic            br_valid,
    input logic [PC_W-1:0] pc,
    input logic            idx_err,
    input logic            nest_err,
    input seq_st_e         st
);
    AST_RESET_LOAD: assert property (@(posedge clk)
        rst |=> (pc == $past(rst_vec)) && !idx_err && !nest_err && (st == ST_IDLE)); // R1

    AST_IDLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) && fetch_adv && !br_valid |=> pc == $past(pc) + PC_W'(1)); // R2

    AST_HOLD_PC: assert property (@(posedge clk) disable iff (rst)
        !fetch_adv |=> $stable(pc) && $stable(st)); // R3

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_SLOT1) || (st == ST_SLOT2)) && fetch_adv |=> pc == $past(pc) + PC_W'(1)); // R4

    AST_SINGLE_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SLOT3) && fetch_adv |=> st == ST_IDLE); // R4

    AST_NEST_FLAG: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) && fetch_adv && br_valid |=> nest_err && (st != ST_SLOT1)); // R12

    AST_NEST_STICKY: assert property (@(posedge clk) disable iff (rst)
        nest_err |=> nest_err); // R12

    AST_IDX_STICKY: assert property (@(posedge clk) disable iff (rst)
        idx_err |=> idx_err); // R11
endmodule

bind dcb_seq dcb_seq_chk #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rst_vec   (rst_vec),
    .fetch_adv (fetch_adv),
    .br_valid  (br_valid),
    .pc        (pc),
    .idx_err   (idx_err),
    .nest_err  (nest_err),
    .st        (st_q)
);

// File: tb/dcb_seq_tb.sv
`timescale 1ns/1ps
module dcb_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] rst_vec = 32'h0000_1000;
    logic        fetch_adv = 1'b0;
    logic        br_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [6:0]  flags = '0;
    logic [4:0]  rf_idx;
    logic [31:0] rf_data;
    logic [31:0] pc;
    logic        idx_err;
    logic        nest_err;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    assign rf_data = 32'h4000_0000 + {23'd0, rf_idx, 4'd0};

    dcb_seq u_dut (
        .clk(clk), .rst(rst), .rst_vec(rst_vec), .fetch_adv(fetch_adv),
        .br_valid(br_valid), .instr(instr), .flags(flags), .rf_idx(rf_idx),
        .rf_data(rf_data), .pc(pc), .idx_err(idx_err), .nest_err(nest_err)
    );

    // {mode, cond[4:0], field[15:0], flags {LUF,LV,UF,N,Z,V,C}, taken}
    localparam logic [29:0] VEC [14] = '{
        {1'b1, 5'd0,  16'h0010, 7'b0000000, 1'b1},
        {1'b1, 5'd5,  16'hFFF0, 7'b0000100, 1'b1},
        {1'b1, 5'd5,  16'h0040, 7'b0000000, 1'b0},
        {1'b0, 5'd1,  16'd5,    7'b0000001, 1'b1},
        {1'b0, 5'd3,  16'd27,   7'b0000000, 1'b1},
        {1'b0, 5'd3,  16'd9,    7'b0000001, 1'b0},
        {1'b1, 5'd8,  16'h8000, 7'b0001000, 1'b1},
        {1'b1, 5'd9,  16'h0030, 7'b0000100, 1'b0},
        {1'b1, 5'd13, 16'h0100, 7'b0000010, 1'b1},
        {1'b1, 5'd20, 16'h0004, 7'b0010000, 1'b1},
        {1'b1, 5'd11, 16'h0020, 7'b1111111, 1'b0},
        {1'b1, 5'd19, 16'h7FFF, 7'b1000000, 1'b1},
        {1'b1, 5'd14, 16'h0050, 7'b0010000, 1'b0},
        {1'b1, 5'd25, 16'h0060, 7'b1111111, 1'b0}
    };

    function automatic logic [31:0] mk(input logic m, input logic [4:0] c, input logic [15:0] f);
        return {6'b011010, m, 4'b0000, c, f};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic br, input logic [31:0] ins);
        fetch_adv = 1'b1;
        br_valid  = br;
        instr     = ins;
        @(negedge clk);
        fetch_adv = 1'b0;
        br_valid  = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] a;
        logic [31:0] e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(pc == rst_vec, "R1 pc", pc, rst_vec);
        chk(!idx_err && !nest_err, "R1 errs", {30'd0, idx_err, nest_err}, 32'd0);
        // R3 hold
        repeat (3) @(negedge clk);
        chk(pc == 32'h1000, "R3 hold", pc, 32'h1000);
        // R2 step
        strobe(1'b0, '0);
        strobe(1'b0, '0);
        chk(pc == 32'h1002, "R2 step", pc, 32'h1002);

        for (int i = 0; i < 14; i++) begin
            logic        m, tk;
            logic [4:0]  c;
            logic [15:0] f;
            logic [6:0]  fl;
            string       tag;
            {m, c, f, fl, tk} = VEC[i];
            a = pc;
            flags = fl;
            strobe(1'b1, mk(m, c, f));
            chk(pc == a + 1, "R4 slot1", pc, a + 1);
            flags = ~fl; // R6: slot flags must not matter
            strobe(1'b0, '0);
            chk(pc == a + 2, "R4 R6 slot2", pc, a + 2);
            strobe(1'b0, '0);
            chk(pc == a + 3, "R4 R6 slot3", pc, a + 3);
            strobe(1'b0, '0);
            if (!tk) e = a + 4;
            else if (m) e = a + 3 + {{16{f[15]}}, f};
            else e = 32'h4000_0000 + {23'd0, f[4:0], 4'd0};
            if (c == 5'd11 || c > 5'd20) tag = "R10 reserved";
            else if (!tk) tag = "R5 R9 not-taken";
            else if (m) tag = "R8 R9 relative";
            else tag = "R7 R9 register";
            chk(pc == e, tag, pc, e);
        end

        // R11 illegal index
        a = pc;
        strobe(1'b1, mk(1'b0, 5'd0, 16'd28));
        chk(idx_err == 1'b1, "R11 flag", {31'd0, idx_err}, 32'd1);
        repeat (3) strobe(1'b0, '0);
        chk(pc == a + 4, "R11 no branch", pc, a + 4);

        // R12 nested branch
        a = pc;
        strobe(1'b1, mk(1'b1, 5'd0, 16'h0020));
        strobe(1'b1, mk(1'b1, 5'd0, 16'h0400));
        chk(nest_err == 1'b1, "R12 flag", {31'd0, nest_err}, 32'd1);
        chk(pc == a + 2, "R12 seq", pc, a + 2);
        @(negedge clk);
        chk(pc == a + 2, "R3 hold pending", pc, a + 2);
        strobe(1'b0, '0);
        strobe(1'b0, '0);
        chk(pc == a + 32'h23, "R12 first target", pc, a + 32'h23);
        strobe(1'b0, '0);
        chk(pc == a + 32'h24, "R12 no second redirect", pc, a + 32'h24);

        // R13 reset while pending
        strobe(1'b1, mk(1'b1, 5'd0, 16'h0200));
        strobe(1'b0, '0);
        do_reset();
        chk(pc == rst_vec, "R13 R1 pc", pc, rst_vec);
        chk(!idx_err && !nest_err, "R1 errs cleared", {30'd0, idx_err, nest_err}, 32'd0);
        repeat (4) strobe(1'b0, '0);
        chk(pc == rst_vec + 4, "R13 no redirect", pc, rst_vec + 4);

        // R2 wrap
        rst_vec = 32'hFFFF_FFFE;
        do_reset();
        strobe(1'b0, '0);
        strobe(1'b0, '0);
        chk(pc == 32'h0, "R2 wrap", pc, 32'h0);
        // R8 wrap of relative target
        do_reset();
        strobe(1'b1, mk(1'b1, 5'd0, 16'h0002));
        strobe(1'b0, '0);
        chk(pc == 32'h0, "R4 wrap slot", pc, 32'h0);
        strobe(1'b0, '0);
        strobe(1'b0, '0);
        chk(pc == 32'h3, "R8 wrap target", pc, 32'h3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule